// File: doc/BRIEF.md
# HDLC Transmit Framer

The framer turns a stream of 10-bit FIFO words into one serial bit stream, advancing one bit for each cycle in which the bit-enable strobe is high. The low byte of every word is payload, and the two top bits mark packet boundaries. In HDLC mode a packet goes out as an opening flag, then its bytes with zero-insertion, then a frame check sequence that is chosen at run time, then a closing flag. While no packet is waiting, the framer keeps sending flags. In raw mode it sends the bytes exactly as they are, with no flags, no stuffing and no check sequence.

The FIFO must present its head word on `fifo_data` while it is not empty. The framer pulses `fifo_rd` for one cycle to consume that word, and the pulse always falls in a cycle where `bit_en` is high. The serial bit is registered and changes only in the cycle after a `bit_en` strobe.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `tx_bit` is 1, `underrun_err` is 0 and `fifo_rd` is 0. The first bits sent are a flag.
- R2: In HDLC mode, while the FIFO is empty between packets, the flag byte 0x7E goes out repeatedly. Bytes are sent LSB first, so each flag is the bit sequence 0,1,1,1,1,1,1,0.
- R3: In HDLC mode, the first word read after a flag starts a packet. Word bit 9 set marks the packet's last byte, and bit 8 marks its first byte: code 01 is first, 00 is middle, 10 is last, and 11 is a one-byte packet. The bytes follow the opening flag LSB first, then the check sequence, then a flag.
- R4: Between flags, a 0 is inserted after every five consecutive 1s in both the payload and the check sequence. Flag bits are never stuffed.
- R5: `crc_sel` = 00 selects CRC-CCITT: reflected polynomial 0x8408, preset 0xFFFF, sent complemented as 2 bytes, low byte first. For the payload "123456789" the bytes are 0x6E then 0x90.
- R6: `crc_sel` = 01 selects CRC16: reflected polynomial 0xA001, preset 0xFFFF, sent complemented as 2 bytes, low byte first. For "123456789" the bytes are 0xC8 then 0xB4.
- R7: `crc_sel` = 1x selects CRC32: reflected polynomial 0xEDB88320, preset all ones, final XOR all ones, 4 bytes low first. For "123456789" the bytes are 0x26, 0x39, 0xF4, 0xCB.
- R8: In raw mode, word bits 7:0 are sent LSB first, back to back, with no stuffing, and bits 9:8 are ignored. While the FIFO is empty, 1s are sent in whole bytes. A byte that is already started always completes.
- R9: If the FIFO is empty when a packet needs its next byte, `underrun_err` is set and stays set until reset. The packet is cut short with a flag and no check sequence.
- R10: `tx_bit` changes only in the cycle after a `bit_en` strobe, and `fifo_rd` is high only when `bit_en` is high and the FIFO is not empty.
- R11: `crc_sel` is captured when a packet's first byte is read. Changing it later in the packet does not alter that packet's check sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | 1 = raw serialization, 0 = HDLC framing |
| crc_sel | input | 2 | Check sequence select: 00 CCITT, 01 CRC16, 1x CRC32 |
| fifo_data | input | 10 | Head FIFO word: bits 9:8 boundary marks, 7:0 data |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | Consume the head word this cycle |
| bit_en | input | 1 | Advance the serial stream by one bit |
| tx_bit | output | 1 | Serial output bit |
| underrun_err | output | 1 | Sticky underrun flag |

## Verification
Two functions can fall on the same `bit_en` strobe. One is a stuffed zero that is due just when a byte ends. The other is the load of the next byte, which may be a check sequence byte or the closing flag. Payloads of all-ones bytes, and bytes whose high bits run into a ones-heavy check sequence, force a stuff bit onto a byte boundary and onto the last check sequence bit before a flag. The bench decodes the captured stream with its own receiver, which removes stuffed zeros and finds flags. It then compares every recovered byte, including the check sequence bytes worked out from the requirements, so a misplaced stuff bit or a lost byte load shows up as a wrong byte or a wrong frame length.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int META_W = 2;
    localparam int WORD_W = BYTE_W + META_W;
    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
    localparam logic [BYTE_W-1:0] RAW_IDLE  = 8'hFF;

    typedef enum logic [1:0] {
        K_FLAG = 2'd0,
        K_DATA = 2'd1,
        K_FCS  = 2'd2,
        K_RAW  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [BYTE_W-1:0] sh;
        logic [2:0]        cnt;
        logic [1:0]        fcs_idx;
        logic [1:0]        sel;
        logic              last;
        logic              out;
        logic              err;
    } fr_state_t;
endpackage

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         step,
    input  logic         din,
    input  logic [1:0]   sel,
    output logic [W-1:0] crc_o,
    output logic [W-1:0] crc_nx_o
);
    logic [W-1:0] crc_q, crc_d, poly, seed, stepped;

    always_comb begin
        case (sel)
            2'b00:   poly = W'(32'h0000_8408);
            2'b01:   poly = W'(32'h0000_A001);
            default: poly = W'(32'hEDB8_8320);
        endcase
        seed    = sel[1] ? '1 : W'(32'h0000_FFFF);
        stepped = (crc_q >> 1) ^ (((crc_q[0] ^ din) == 1'b1) ? poly : '0);
        if (init)       crc_d = seed;
        else if (step)  crc_d = stepped;
        else            crc_d = crc_q;
        crc_o    = crc_q;
        crc_nx_o = crc_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/hdlc_stuff_ctr.sv
module hdlc_stuff_ctr #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic counts,
    input  logic bit_in,
    output logic stuff_now
);
    localparam int CW = $clog2(RUN + 1);
    logic [CW-1:0] ones_d, ones_q;

    always_comb begin
        ones_d = ones_q;
        if (adv) ones_d = (counts && bit_in) ? ones_q + CW'(1) : '0;
        stuff_now = (ones_q == CW'(RUN));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end

    // R4: a run of ones never grows past the stuffing limit
    p_run_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= CW'(RUN));
    // R4: the bit emitted while a stuff is due clears the run
    p_stuff_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_now && adv) |=> (ones_q == '0));
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int STUFF_RUN = 5,
    parameter int CRC_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic [1:0]        crc_sel,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    input  logic              bit_en,
    output logic              tx_bit,
    output logic              underrun_err
);
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    fr_state_t           st_q, st_d;
    logic                crc_init, crc_step, stuff_now, emit_bit, emit_counts;
    logic [CRC_W-1:0]    crc_q, crc_nx;
    logic [1:0]          last_idx, nxt_idx;
    logic [4:0]          nxt_base;

    hdlc_crc_unit #(.W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .step(crc_step),
        .din(st_q.sh[0]), .sel(st_d.sel), .crc_o(crc_q), .crc_nx_o(crc_nx)
    );

    hdlc_stuff_ctr #(.RUN(STUFF_RUN)) u_stuff (
        .clk(clk), .rst_n(rst_n), .adv(bit_en), .counts(emit_counts),
        .bit_in(emit_bit), .stuff_now(stuff_now)
    );

    always_comb begin
        st_d        = st_q;
        fifo_rd     = 1'b0;
        crc_init    = 1'b0;
        crc_step    = 1'b0;
        emit_bit    = 1'b0;
        emit_counts = 1'b0;
        last_idx    = st_q.sel[1] ? 2'd3 : 2'd1;
        nxt_idx     = st_q.fcs_idx + 2'd1;
        nxt_base    = {nxt_idx, 3'b000};
        if (bit_en) begin
            if (stuff_now) begin
                st_d.out = 1'b0;
            end else begin
                emit_bit    = st_q.sh[0];
                emit_counts = (st_q.kind == K_DATA) || (st_q.kind == K_FCS);
                crc_step    = (st_q.kind == K_DATA);
                st_d.out    = st_q.sh[0];
                st_d.sh     = st_q.sh >> 1;
                st_d.cnt    = st_q.cnt + 3'd1;
                if (st_q.cnt == LAST_BIT) begin
                    case (st_q.kind)
                        K_DATA: begin
                            if (st_q.last) begin
                                st_d.kind    = K_FCS;
                                st_d.fcs_idx = 2'd0;
                                st_d.sh      = ~crc_nx[7:0];
                            end else if (fifo_empty) begin
                                st_d.err  = 1'b1;
                                st_d.kind = K_FLAG;
                                st_d.sh   = FLAG_BYTE;
                            end else begin
                                fifo_rd   = 1'b1;
                                st_d.sh   = fifo_data[BYTE_W-1:0];
                                st_d.last = fifo_data[WORD_W-1];
                            end
                        end
                        K_FCS: begin
                            if (st_q.fcs_idx == last_idx) begin
                                st_d.kind = K_FLAG;
                                st_d.sh   = FLAG_BYTE;
                            end else begin
                                st_d.fcs_idx = nxt_idx;
                                st_d.sh      = ~crc_q[nxt_base +: 8];
                            end
                        end
                        default: begin
                            if (raw_mode) begin
                                st_d.kind = K_RAW;
                                if (!fifo_empty) begin
                                    fifo_rd = 1'b1;
                                    st_d.sh = fifo_data[BYTE_W-1:0];
                                end else begin
                                    st_d.sh = RAW_IDLE;
                                end
                            end else if (st_q.kind == K_FLAG && !fifo_empty) begin
                                fifo_rd   = 1'b1;
                                crc_init  = 1'b1;
                                st_d.kind = K_DATA;
                                st_d.sel  = crc_sel;
                                st_d.sh   = fifo_data[BYTE_W-1:0];
                                st_d.last = fifo_data[WORD_W-1];
                            end else begin
                                st_d.kind = K_FLAG;
                                st_d.sh   = FLAG_BYTE;
                            end
                        end
                    endcase
                end
            end
        end
        tx_bit       = st_q.out;
        underrun_err = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{kind: K_FLAG, sh: FLAG_BYTE, cnt: 3'd0, fcs_idx: 2'd0,
                      sel: 2'd0, last: 1'b0, out: 1'b1, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R10: reads only on a bit strobe with a word present
    p_rd_on_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (bit_en && !fifo_empty));
    // R10: output holds without a strobe
    p_hold_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    // R9: the underrun flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err |=> underrun_err);
    // R11: the captured check selection holds through a packet
    p_sel_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_init && st_q.kind != K_FLAG && st_q.kind != K_RAW) |=> $stable(st_q.sel));
endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_mode = 1'b0;
    logic [1:0] crc_sel = 2'b00;
    logic [9:0] fifo_data;
    logic       fifo_empty, fifo_rd, bit_en = 1'b0, tx_bit, underrun_err;

    logic [9:0] mem [0:63];
    logic [6:0] wr_ptr = '0, rd_ptr;
    logic       cap [0:2047];
    int         cap_n;
    logic [7:0] dec [0:127];
    int         dec_n;
    logic [7:0] pay [0:63];
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = mem[rd_ptr[5:0]];
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_ptr <= '0;
        else if (fifo_rd) rd_ptr <= rd_ptr + 7'd1;
    end

    hdlc_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .crc_sel(crc_sel),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .bit_en(bit_en), .tx_bit(tx_bit), .underrun_err(underrun_err)
    );

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; wr_ptr = '0; cap_n = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [9:0] w);
        mem[wr_ptr[5:0]] = w;
        wr_ptr = wr_ptr + 7'd1;
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_en = 1'b1;
            @(negedge clk); bit_en = 1'b0;
            cap[cap_n] = tx_bit; cap_n++;
        end
    endtask

    // Receiver: removes stuffed zeros, keeps the first non-empty frame
    task automatic decode();
        int ones = 0, nb = 0;
        logic bb [0:2047];
        dec_n = -1;
        for (int i = 0; i < cap_n; i++) begin
            if (cap[i]) begin
                ones++; bb[nb] = 1'b1; nb++;
            end else if (ones == 5) begin
                ones = 0;
            end else if (ones == 6) begin
                if (nb - 7 > 0 && dec_n < 0) begin
                    dec_n = (nb - 7) / 8;
                    for (int k = 0; k < dec_n; k++)
                        for (int j = 0; j < 8; j++) dec[k][j] = bb[k*8+j];
                end
                nb = 0; ones = 0;
            end else begin
                ones = 0; bb[nb] = 1'b0; nb++;
            end
        end
    endtask

    function automatic logic [31:0] ref_fcs(input logic [1:0] sel, input int len);
        logic [31:0] c, p;
        c = sel[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        p = (sel == 2'b00) ? 32'h8408 : (sel == 2'b01) ? 32'hA001 : 32'hEDB8_8320;
        for (int i = 0; i < len; i++)
            for (int j = 0; j < 8; j++)
                c = (c >> 1) ^ (((c[0] ^ pay[i][j]) == 1'b1) ? p : 32'h0);
        return ~c;
    endfunction

    task automatic send_pkt(input logic [1:0] sel, input int len);
        for (int i = 0; i < len; i++)
            push({(i == len - 1), (i == 0), pay[i]});
        crc_sel = sel;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic check_frame(input logic [1:0] sel, input int len, input string req,
                               input logic [31:0] fcs);
        int nf;
        nf = sel[1] ? 4 : 2;
        decode();
        chk(dec_n == len + nf, {req, " frame length"}, dec_n, len + nf);
        for (int i = 0; i < len; i++)
            chk(dec[i] == pay[i], {req, " payload byte"}, dec[i], pay[i]);
        for (int i = 0; i < nf; i++)
            chk(dec[len+i] == fcs[i*8 +: 8], {req, " fcs byte"}, dec[len+i], fcs[i*8 +: 8]);
    endtask

    // {sel, len, seed, step}
    localparam logic [25:0] VEC [0:4] = '{
        {2'd0, 8'd1,  8'h7E, 8'h00},
        {2'd1, 8'd5,  8'hFF, 8'h00},
        {2'd2, 8'd6,  8'h00, 8'h11},
        {2'd0, 8'd12, 8'hF8, 8'h03},
        {2'd3, 8'd3,  8'h3F, 8'h40}
    };

    initial begin
        logic [7:0] exp_raw [0:3];
        logic [7:0] got;

        // R1: reset state
        do_reset();
        @(negedge clk); rst_n = 1'b1;
        chk(tx_bit == 1'b1, "R1 tx_bit", tx_bit, 1);
        chk(underrun_err == 1'b0, "R1 underrun_err", underrun_err, 0);
        chk(fifo_rd == 1'b0, "R1 fifo_rd", fifo_rd, 0);
        // R2: idle flags with empty FIFO
        run_bits(24);
        for (int f = 0; f < 3; f++) begin
            for (int j = 0; j < 8; j++) got[j] = cap[f*8+j];
            chk(got == 8'h7E, "R2 idle flag", got, 8'h7E);
        end

        // R3 R4: table of packets, stuffing forced by ones-heavy bytes
        for (int v = 0; v < 5; v++) begin
            logic [1:0] s; int ln;
            s  = VEC[v][25:24];
            ln = int'(VEC[v][23:16]);
            do_reset();
            for (int i = 0; i < ln; i++) pay[i] = VEC[v][15:8] + 8'(i) * VEC[v][7:0];
            send_pkt(s, ln);
            run_bits(8 * (ln + 8) + 2 * ln + 40);
            check_frame(s, ln, "R3 R4 table", ref_fcs(s, ln));
        end

        // R5 R6 R7: known check values of "123456789"
        for (int s = 0; s < 3; s++) begin
            logic [31:0] kv;
            do_reset();
            for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
            send_pkt(2'(s), 9);
            run_bits(220);
            kv = (s == 0) ? 32'h0000_906E : (s == 1) ? 32'h0000_B4C8 : 32'hCBF4_3926;
            check_frame(2'(s), 9, (s == 0) ? "R5" : (s == 1) ? "R6" : "R7", kv);
        end

        // R11: selection changed mid-packet has no effect
        do_reset();
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
        send_pkt(2'b00, 9);
        run_bits(30);
        crc_sel = 2'b10;
        run_bits(190);
        check_frame(2'b00, 9, "R11", 32'h0000_906E);

        // R8: raw mode, meta ignored, no stuffing, idle ones
        do_reset();
        raw_mode = 1'b1;
        exp_raw = '{8'hFF, 8'hFF, 8'h0F, 8'hFF};
        push({2'b10, 8'hFF}); push({2'b11, 8'hFF}); push({2'b01, 8'h0F});
        @(negedge clk); rst_n = 1'b1;
        run_bits(48);
        for (int b = 0; b < 4; b++) begin
            for (int j = 0; j < 8; j++) got[j] = cap[8 + b*8 + j];
            chk(got == exp_raw[b], "R8 raw byte", got, exp_raw[b]);
        end
        raw_mode = 1'b0;

        // R9 R10: underrun aborts with flags, sticky error, output holds
        do_reset();
        push({2'b01, 8'h55});
        @(negedge clk); rst_n = 1'b1;
        run_bits(12);
        chk(underrun_err == 1'b0, "R9 no error mid byte", underrun_err, 0);
        begin
            logic hold;
            hold = tx_bit;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                chk(tx_bit == hold && fifo_rd == 1'b0, "R10 hold without strobe", tx_bit, hold);
            end
        end
        run_bits(28);
        chk(underrun_err == 1'b1, "R9 error set", underrun_err, 1);
        for (int f = 0; f < 3; f++) begin
            for (int j = 0; j < 8; j++) got[j] = cap[16 + f*8 + j];
            chk(got == 8'h7E, "R9 abort flag", got, 8'h7E);
        end
        push({2'b11, 8'hA5});
        run_bits(60);
        chk(underrun_err == 1'b1, "R9 error sticky", underrun_err, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule